// File: doc/BRIEF.md
# Transactional Read/Write Signature Conflict Unit

This block gives hardware help to a hybrid transactional memory. Software keeps the write buffer, the checkpoint and the commit loop. The block keeps two Bloom-filter signatures of word addresses: the read set and the write set. Software adds addresses to them with barrier commands. Every coherence request seen on the snoop port is looked up against whichever signature the current transaction phase watches. The result comes back as a conflict (software must abort the transaction) or as a NACK (the requester is refused and retries later).

Four phases drive the behaviour: idle, active, acquire and write-back.
- **Active:** only exclusive requests are checked, and only against the read set.
- **Acquire:** the write set is checked for every request type and a hit is a conflict. The read set is still checked for exclusive requests.
- **Write-back:** the read set has been dropped. Write-set hits are refused with a NACK instead of reported as conflicts.

An abort command resets everything in one cycle.

Top module: `sigcu_top`

## Requirements
- R1: After reset the unit is idle, both signatures are empty, and `conflict_o` and `nack_o` stay low for every snoop until a transaction begins.
- R2: Each signature has 256 bits and uses two indices of the 32-bit word address a.
  - Index A is a[7:0]^a[15:8]^a[23:16]^a[31:24].
  - Index B is {a[3:0],4'b0}^a[11:4]^a[19:12]^a[27:20]^{4'b0,a[31:28]}.
  - An insert sets both bits. A lookup hits only when both bits are set, so false positives follow from this formula.
- R3: Command codes on `cmd_op` are: 0 no-op, 1 begin, 2 read barrier, 3 write barrier, 4 commit, 5 owned, 6 drained, 7 abort. A read barrier inserts `cmd_addr` into the read signature and a write barrier into the write signature, only in the active phase; elsewhere both are ignored.
- R4: In the active phase an exclusive snoop (`snp_excl`=1) that hits the read signature raises `conflict_o`. A shared snoop never does, and the write signature is not consulted.
- R5: No false negatives: an inserted address always hits its signature until that signature is cleared.
- R6: Commit (from active) enters the acquire phase. There any snoop hitting the write signature, and any exclusive snoop hitting the read signature, raises `conflict_o`. `nack_o` stays low.
- R7: Owned (from acquire) clears the read signature and enters write-back. There a snoop of either type hitting the write signature raises `nack_o`, and `conflict_o` stays low.
- R8: Drained (from write-back) clears the write signature, ends NACKing and returns to idle.
- R9: Abort, in any phase, clears both signatures and all lookup enables and returns to idle by the next cycle.
- R10: A begin outside idle, a commit outside active, an owned outside acquire and a drained outside write-back have no effect.
- R11: `conflict_o` and `nack_o` are registered. They reflect the snoop presented in the previous cycle and are low when `snp_valid` was low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Command code (R3) |
| cmd_addr | input | 32 | Word address for barrier commands |
| snp_valid | input | 1 | Snoop request present |
| snp_excl | input | 1 | 1 = exclusive request, 0 = shared |
| snp_addr | input | 32 | Snooped word address |
| conflict_o | output | 1 | Conflict: transaction must abort |
| nack_o | output | 1 | Refuse the snooped request |

## Verification
Each phase gets a sweep of several hundred spread addresses, issued once as shared and once as exclusive. The expected result comes from the hash arithmetic applied to a mirror of the inserted sets. These sweeps separate:
- read-set checks from write-set checks;
- request type filtering;
- conflict from NACK;
- true hits from false-positive aliases.

Directed snoops of every inserted address show there are no false negatives. Commands issued in the wrong phase, and aborts in the acquire and write-back phases, are followed by a sweep that must find empty signatures.

// File: rtl/sigcu_pkg.sv
package sigcu_pkg;
  typedef enum logic [1:0] {
    PH_IDLE      = 2'd0,
    PH_ACTIVE    = 2'd1,
    PH_ACQUIRE   = 2'd2,
    PH_WRITEBACK = 2'd3
  } phase_e;

  typedef enum logic [2:0] {
    OP_NOP     = 3'd0,
    OP_BEGIN   = 3'd1,
    OP_RDBAR   = 3'd2,
    OP_WRBAR   = 3'd3,
    OP_COMMIT  = 3'd4,
    OP_OWNED   = 3'd5,
    OP_DRAINED = 3'd6,
    OP_ABORT   = 3'd7
  } op_e;
endpackage

// File: rtl/sigcu_hash.sv
module sigcu_hash #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 8
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [IDX_W-1:0]  idx_a,
  output logic [IDX_W-1:0]  idx_b
);
  localparam int SHIFT_B = IDX_W / 2;
  localparam int NSL_A   = (ADDR_W + IDX_W - 1) / IDX_W;
  localparam int NSL_B   = (ADDR_W + SHIFT_B + IDX_W - 1) / IDX_W;

  logic [NSL_A*IDX_W-1:0] pad_a;
  logic [NSL_B*IDX_W-1:0] pad_b;

  // Hash A folds the address in plain slices; hash B folds it offset by half a slice.
  always_comb begin
    pad_a = '0;
    pad_a[ADDR_W-1:0] = addr;
    idx_a = '0;
    for (int k = 0; k < NSL_A; k++) begin
      idx_a = idx_a ^ pad_a[k*IDX_W +: IDX_W];
    end
  end

  always_comb begin
    pad_b = '0;
    pad_b[ADDR_W+SHIFT_B-1:SHIFT_B] = addr;
    idx_b = '0;
    for (int k = 0; k < NSL_B; k++) begin
      idx_b = idx_b ^ pad_b[k*IDX_W +: IDX_W];
    end
  end
endmodule

// File: rtl/sigcu_filter.sv
module sigcu_filter #(
  parameter int SIG_BITS = 256,
  localparam int IDX_W   = $clog2(SIG_BITS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ins,
  input  logic [IDX_W-1:0] ins_a,
  input  logic [IDX_W-1:0] ins_b,
  input  logic             clr,
  input  logic [IDX_W-1:0] look_a,
  input  logic [IDX_W-1:0] look_b,
  output logic             hit
);
  logic [SIG_BITS-1:0] sig_q;
  logic [SIG_BITS-1:0] sig_d;

  for (genvar b = 0; b < SIG_BITS; b++) begin : g_cell
    logic sel;
    assign sel      = ins && ((ins_a == IDX_W'(b)) || (ins_b == IDX_W'(b)));
    assign sig_d[b] = clr ? 1'b0 : (sig_q[b] | sel);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sig_q <= '0;
    else        sig_q <= sig_d;
  end

  assign hit = sig_q[look_a] & sig_q[look_b];

  // R2
  ins_sets_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ins && !clr) |=> (sig_q[$past(ins_a)] && sig_q[$past(ins_b)]));
  // R5
  no_lost_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (($past(sig_q) & ~sig_q) == '0));
  // R9
  clear_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (sig_q == '0));
endmodule

// File: rtl/sigcu_ctrl.sv
module sigcu_ctrl
  import sigcu_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [2:0] cmd_op,
  input  logic       snp_valid,
  input  logic       snp_excl,
  input  logic       rd_hit,
  input  logic       wr_hit,
  output logic       rd_ins,
  output logic       wr_ins,
  output logic       rd_clr,
  output logic       wr_clr,
  output logic       conflict_o,
  output logic       nack_o
);
  phase_e phase_q, phase_d;
  logic   rd_look_q, rd_look_d;
  logic   wr_look_q, wr_look_d;
  logic   nack_en_q, nack_en_d;
  logic   conflict_d, nack_d;
  op_e    op;

  logic do_begin, do_commit, do_owned, do_drained, do_abort;

  assign op         = op_e'(cmd_op);
  assign do_abort   = cmd_valid && (op == OP_ABORT);
  assign do_begin   = cmd_valid && (op == OP_BEGIN)   && (phase_q == PH_IDLE);
  assign do_commit  = cmd_valid && (op == OP_COMMIT)  && (phase_q == PH_ACTIVE);
  assign do_owned   = cmd_valid && (op == OP_OWNED)   && (phase_q == PH_ACQUIRE);
  assign do_drained = cmd_valid && (op == OP_DRAINED) && (phase_q == PH_WRITEBACK);

  assign rd_ins = cmd_valid && (op == OP_RDBAR) && (phase_q == PH_ACTIVE);
  assign wr_ins = cmd_valid && (op == OP_WRBAR) && (phase_q == PH_ACTIVE);
  assign rd_clr = do_abort || do_owned;
  assign wr_clr = do_abort || do_drained;

  // Phase and lookup enables: next-state.
  always_comb begin
    phase_d   = phase_q;
    rd_look_d = rd_look_q;
    wr_look_d = wr_look_q;
    nack_en_d = nack_en_q;
    if (do_abort) begin
      phase_d   = PH_IDLE;
      rd_look_d = 1'b0;
      wr_look_d = 1'b0;
      nack_en_d = 1'b0;
    end else if (do_begin) begin
      phase_d   = PH_ACTIVE;
      rd_look_d = 1'b1;
    end else if (do_commit) begin
      phase_d   = PH_ACQUIRE;
      wr_look_d = 1'b1;
    end else if (do_owned) begin
      phase_d   = PH_WRITEBACK;
      rd_look_d = 1'b0;
      nack_en_d = 1'b1;
    end else if (do_drained) begin
      phase_d   = PH_IDLE;
      wr_look_d = 1'b0;
      nack_en_d = 1'b0;
    end
  end

  // Snoop response: next-state.
  always_comb begin
    conflict_d = snp_valid &&
                 ((rd_look_q && snp_excl && rd_hit) ||
                  (wr_look_q && !nack_en_q && wr_hit));
    nack_d     = snp_valid && nack_en_q && wr_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q    <= PH_IDLE;
      rd_look_q  <= 1'b0;
      wr_look_q  <= 1'b0;
      nack_en_q  <= 1'b0;
      conflict_o <= 1'b0;
      nack_o     <= 1'b0;
    end else begin
      phase_q    <= phase_d;
      rd_look_q  <= rd_look_d;
      wr_look_q  <= wr_look_d;
      nack_en_q  <= nack_en_d;
      conflict_o <= conflict_d;
      nack_o     <= nack_d;
    end
  end

  // R7
  nack_excludes_conflict_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(nack_o && conflict_o));
  // R7
  nack_only_writeback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nack_en_q |-> (phase_q == PH_WRITEBACK));
  // R4
  shared_active_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && !snp_excl && (phase_q == PH_ACTIVE)) |=> !conflict_o);
  // R11
  no_snoop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !snp_valid |=> (!conflict_o && !nack_o));
  // R9
  abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    do_abort |=> ((phase_q == PH_IDLE) && !rd_look_q && !wr_look_q && !nack_en_q));
  // R10
  writeback_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_WRITEBACK) |=> (phase_q inside {PH_WRITEBACK, PH_IDLE}));
endmodule

// File: rtl/sigcu_top.sv
module sigcu_top #(
  parameter int ADDR_W   = 32,
  parameter int SIG_BITS = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              snp_valid,
  input  logic              snp_excl,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              conflict_o,
  output logic              nack_o
);
  localparam int IDX_W = $clog2(SIG_BITS);

  logic [IDX_W-1:0] ins_a, ins_b, look_a, look_b;
  logic rd_ins, wr_ins, rd_clr, wr_clr, rd_hit, wr_hit;

  sigcu_hash #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_hash_cmd (
    .addr(cmd_addr), .idx_a(ins_a), .idx_b(ins_b));

  sigcu_hash #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_hash_snp (
    .addr(snp_addr), .idx_a(look_a), .idx_b(look_b));

  sigcu_filter #(.SIG_BITS(SIG_BITS)) u_rd_sig (
    .clk(clk), .rst_n(rst_n), .ins(rd_ins), .ins_a(ins_a), .ins_b(ins_b),
    .clr(rd_clr), .look_a(look_a), .look_b(look_b), .hit(rd_hit));

  sigcu_filter #(.SIG_BITS(SIG_BITS)) u_wr_sig (
    .clk(clk), .rst_n(rst_n), .ins(wr_ins), .ins_a(ins_a), .ins_b(ins_b),
    .clr(wr_clr), .look_a(look_a), .look_b(look_b), .hit(wr_hit));

  sigcu_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .snp_valid(snp_valid), .snp_excl(snp_excl), .rd_hit(rd_hit), .wr_hit(wr_hit),
    .rd_ins(rd_ins), .wr_ins(wr_ins), .rd_clr(rd_clr), .wr_clr(wr_clr),
    .conflict_o(conflict_o), .nack_o(nack_o));
endmodule

// File: tb/sigcu_top_tb.sv
`timescale 1ns/1ps
module sigcu_top_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_valid;
  logic [2:0]  cmd_op;
  logic [31:0] cmd_addr;
  logic        snp_valid;
  logic        snp_excl;
  logic [31:0] snp_addr;
  logic        conflict_o;
  logic        nack_o;

  int vectors = 0;
  int fails   = 0;
  bit done    = 1'b0;

  // Mirror of the requirement-level state
  bit [255:0] m_rs, m_ws;
  int         m_ph;   // 0 idle, 1 active, 2 acquire, 3 write-back
  bit         m_rl, m_wl, m_nk;

  always #2 clk = ~clk;

  sigcu_top u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .snp_valid(snp_valid), .snp_excl(snp_excl),
    .snp_addr(snp_addr), .conflict_o(conflict_o), .nack_o(nack_o));

  // R2 index formulas
  function automatic int ha(bit [31:0] a);
    return int'(a[7:0] ^ a[15:8] ^ a[23:16] ^ a[31:24]);
  endfunction
  function automatic int hb(bit [31:0] a);
    bit [39:0] s;
    bit [7:0]  x;
    s = {a, 4'b0000};
    x = 8'h00;
    for (int k = 0; k < 5; k++) x = x ^ s[k*8 +: 8];
    return int'(x);
  endfunction

  task automatic check(string req, bit exp_c, bit exp_n, bit [31:0] a);
    vectors++;
    if (conflict_o !== exp_c || nack_o !== exp_n) begin
      fails++;
      $display("FAIL %s addr=%h actual conflict=%b nack=%b expected conflict=%b nack=%b",
               req, a, conflict_o, nack_o, exp_c, exp_n);
    end
  endtask

  task automatic op(int code, bit [31:0] a);
    cmd_valid = 1'b1;
    cmd_op    = 3'(code);
    cmd_addr  = a;
    case (code)
      1: if (m_ph == 0) begin m_ph = 1; m_rl = 1; end
      2: if (m_ph == 1) begin m_rs[ha(a)] = 1; m_rs[hb(a)] = 1; end
      3: if (m_ph == 1) begin m_ws[ha(a)] = 1; m_ws[hb(a)] = 1; end
      4: if (m_ph == 1) begin m_ph = 2; m_wl = 1; end
      5: if (m_ph == 2) begin m_ph = 3; m_rl = 0; m_nk = 1; m_rs = '0; end
      6: if (m_ph == 3) begin m_ph = 0; m_wl = 0; m_nk = 0; m_ws = '0; end
      7: begin m_ph = 0; m_rl = 0; m_wl = 0; m_nk = 0; m_rs = '0; m_ws = '0; end
      default: ;
    endcase
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic snoop(string req, bit [31:0] a, bit ex, bit vld);
    bit rh, wh, ec, en;
    rh = m_rs[ha(a)] && m_rs[hb(a)];
    wh = m_ws[ha(a)] && m_ws[hb(a)];
    ec = vld && ((m_rl && ex && rh) || (m_wl && !m_nk && wh));
    en = vld && m_nk && wh;
    snp_valid = vld;
    snp_excl  = ex;
    snp_addr  = a;
    @(negedge clk);
    check(req, ec, en, a);
    snp_valid = 1'b0;
  endtask

  task automatic sweep(string req, bit [31:0] seed, int n);
    for (int i = 0; i < n; i++) begin
      bit [31:0] a;
      a = seed + 32'(i) * 32'h9E37_79B1;
      snoop(req, a, 1'b0, 1'b1);
      snoop(req, a, 1'b1, 1'b1);
    end
  endtask

  function automatic bit [31:0] raddr(int i);
    return 32'h0000_1000 + 32'(i) * 32'h0000_0104;
  endfunction
  function automatic bit [31:0] waddr(int i);
    return 32'h8000_0000 + 32'(i) * 32'h0000_2301;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    m_rs = '0; m_ws = '0; m_ph = 0; m_rl = 0; m_wl = 0; m_nk = 0;
    cmd_valid = 0; cmd_op = 0; cmd_addr = 0;
    snp_valid = 0; snp_excl = 0; snp_addr = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1", 1'b0, 1'b0, 32'h0);
    sweep("R1", 32'h0000_0000, 64);

    // R10 / R3: out-of-phase commands and barriers in idle are ignored
    op(2, raddr(0));
    op(3, waddr(0));
    op(4, 0); op(5, 0); op(6, 0);
    op(1, 0);
    snoop("R3", raddr(0), 1'b1, 1'b1);
    op(5, 0); op(6, 0); op(1, 0);   // R10: no effect while active
    snoop("R10", raddr(0), 1'b1, 1'b1);

    for (int i = 0; i < 6; i++) op(2, raddr(i));
    for (int i = 0; i < 6; i++) op(3, waddr(i));
    for (int i = 0; i < 6; i++) begin
      snoop("R5", raddr(i), 1'b1, 1'b1);
      vectors++;
      if (conflict_o !== 1'b1) begin
        fails++;
        $display("FAIL R5 read addr %h actual conflict=%b expected 1", raddr(i), conflict_o);
      end
    end
    snoop("R11", raddr(1), 1'b1, 1'b0);
    sweep("R4", 32'h0000_1000, 256);
    for (int i = 0; i < 6; i++) snoop("R4", waddr(i), 1'b0, 1'b1);

    op(4, 0);
    op(1, 0); op(2, 32'h0000_0777);  // R10 begin ignored, R3 barrier ignored
    snoop("R3", 32'h0000_0777, 1'b1, 1'b1);
    for (int i = 0; i < 6; i++) begin
      snoop("R6", waddr(i), 1'b0, 1'b1);
      vectors++;
      if (conflict_o !== 1'b1) begin
        fails++;
        $display("FAIL R6 write addr %h actual conflict=%b expected 1", waddr(i), conflict_o);
      end
    end
    sweep("R6", 32'h8000_0000, 256);

    op(5, 0);
    for (int i = 0; i < 6; i++) begin
      snoop("R7", waddr(i), 1'b1, 1'b1);
      vectors++;
      if (nack_o !== 1'b1 || conflict_o !== 1'b0) begin
        fails++;
        $display("FAIL R7 write addr %h actual nack=%b conflict=%b expected 1 0",
                 waddr(i), nack_o, conflict_o);
      end
    end
    sweep("R7", 32'h0000_1000, 256);
    sweep("R7", 32'h8000_0000, 128);

    op(6, 0);
    sweep("R8", 32'h8000_0000, 128);
    for (int i = 0; i < 6; i++) snoop("R8", waddr(i), 1'b0, 1'b1);

    // R9: abort in the acquire phase
    op(1, 0);
    for (int i = 0; i < 8; i++) op(2, 32'h00C0_FFEE ^ (32'(i) << 5));
    for (int i = 0; i < 8; i++) op(3, 32'h5A5A_0000 + 32'(i) * 32'h0003_0011);
    op(4, 0);
    sweep("R6", 32'h00C0_FFEE, 64);
    op(7, 0);
    sweep("R9", 32'h00C0_FFEE, 64);
    op(1, 0);
    for (int i = 0; i < 8; i++) snoop("R9", 32'h00C0_FFEE ^ (32'(i) << 5), 1'b1, 1'b1);
    sweep("R9", 32'h5A5A_0000, 64);

    // R9: abort in the write-back phase
    for (int i = 0; i < 8; i++) op(3, 32'h1234_0000 + 32'(i) * 32'h0101_0101);
    op(4, 0); op(5, 0);
    sweep("R7", 32'h1234_0000, 64);
    op(7, 0);
    for (int i = 0; i < 8; i++) snoop("R9", 32'h1234_0000 + 32'(i) * 32'h0101_0101, 1'b0, 1'b1);
    sweep("R9", 32'h1234_0000, 64);

    // Dense third round: many inserts force false-positive aliases
    op(1, 0);
    for (int i = 0; i < 40; i++) op(2, 32'(i) * 32'h0001_0003);
    for (int i = 0; i < 40; i++) op(3, 32'(i) * 32'h0700_0101);
    sweep("R2", 32'h0000_0000, 512);
    op(4, 0);
    sweep("R2", 32'h0000_0000, 512);
    op(5, 0);
    sweep("R2", 32'h0000_0000, 256);
    op(6, 0);
    sweep("R8", 32'h0000_0000, 64);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule